// File: doc/BRIEF.md
# Line-Doubling Serial Framebuffer Scanout

This block turns a one-bit-per-pixel framebuffer into a serial video stream for an 800x600-class display. It keeps its own dot and line counters and drives an active-low horizontal sync and an active-high vertical sync from them. It fetches pixel bytes through a byte-wide read port with a one-cycle read latency and shifts each byte out most significant bit first. Every bit is held for two dot clocks, so one byte spans sixteen dots.

Every stored row is drawn on two consecutive display lines, so the stored image has half as many rows as the display has visible lines. Once per frame the block arms a frame-valid flag at the line where sync plus back porch ends. A line transfer can start only while that flag is set. When the last stored row has been drawn twice, the row pointer jumps back to the buffer base and the flag clears. The base address comes from an input. It is sampled only at reset and at that wrap point, so software can switch between two buffers with no tearing.

Top module: `fb_scanout`

## Requirements
- R1: `hsync_n_o` is low for the first H_SYNC dots of every HTOT = H_VIS+H_FP+H_SYNC+H_BP dot line and high for the rest.
- R2: `vsync_o` is high during the first V_SYNC lines of every VTOT = V_VIS+V_FP+V_SYNC+V_BP line frame and low otherwise.
- R3: The frame-valid flag is set on line V_SYNC+V_BP. A transfer starts only on lines from there to V_SYNC+V_BP+V_VIS-1, in the cycle where the dot counter equals H_SYNC+H_BP. The first read is issued in that cycle, and the first pixel appears two cycles later.
- R4: Each transfer sends H_VIS/16+2 bytes. Each byte goes out bit 7 first, and every bit is held for two clock cycles.
- R5: `pix_o` is 0 whenever no transfer is in progress.
- R6: Byte k of a line is read from row address + k. Byte 0 is read in the start cycle. Byte k+1 is read in the first cycle that byte k is on the output, so a byte is always fetched before it is needed.
- R7: Each stored row is sent on two consecutive lines. The row address grows by H_VIS/16+2 only after the second send.
- R8: After the last of the V_VIS/2 stored rows has been sent twice, the row address returns to the base and the frame-valid flag clears. No transfer starts again until line V_SYNC+V_BP of the next frame.
- R9: A change on `base_i` has no effect on the current frame. It is first used by the frame that follows the next wrap.
- R10: While `rst_n` is low, `pix_o` and `rd_en_o` are 0 and both counters sit at zero, so `hsync_n_o` is 0 and `vsync_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_i | input | ADDR_W | Buffer base address, sampled at frame wrap |
| rd_en_o | output | 1 | Read strobe to the framebuffer memory |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_en_o` |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| pix_o | output | 1 | Serial pixel stream |

## Verification
The bench builds the block with a 100-dot line (64 visible, 8 front porch, 8 sync, 20 back porch) and a 14-line frame (8 visible, 1 front porch, 2 sync, 3 back porch). A line then carries six bytes and a frame holds four stored rows. With this configuration three whole frames fit in a few thousand cycles. Every cycle's sync levels, read strobe, read address and pixel bit are compared with values computed arithmetically from the cycle count. This covers each doubled row, every transfer that spills past its line end, both frame wraps, and a base switch made in mid-frame that must wait for the wrap.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_VIS  = 800,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 72,
  parameter int H_BP   = 128,
  parameter int V_VIS  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 22,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              hsync_n_o,
  output logic              vsync_o,
  output logic              pix_o
);
  localparam int HTOT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VTOT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int START = H_SYNC + H_BP;
  localparam int VSB   = V_SYNC + V_BP;
  localparam int BYTES = H_VIS / 16 + 2;
  localparam int ROWS  = V_VIS / 2;
  localparam int HW    = $clog2(HTOT);
  localparam int VW    = $clog2(VTOT);
  localparam int IW    = $clog2(BYTES + 1);
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [HW-1:0]     hcnt;
  logic [VW-1:0]     vcnt;
  logic              valid, prime, busy, rd_q, rep;
  logic [3:0]        phase;
  logic [IW-1:0]     idx;
  logic [7:0]        sh, hold;
  logic [RW-1:0]     row;
  logic [ADDR_W-1:0] row_addr;

  wire h_end     = hcnt == HW'(HTOT - 1);
  wire start     = valid && !busy && !prime && hcnt == HW'(START);
  wire fetch     = busy && phase == 4'd0 && idx < IW'(BYTES);
  wire line_done = busy && phase == 4'hF && idx == IW'(BYTES);

  assign hsync_n_o = hcnt >= HW'(H_SYNC);
  assign vsync_o   = vcnt < VW'(V_SYNC);
  assign rd_en_o   = start | fetch;
  assign rd_addr_o = row_addr + (start ? '0 : ADDR_W'(idx));
  assign pix_o     = busy & sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (h_end) vcnt <= (vcnt == VW'(VTOT - 1)) ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      prime    <= 1'b0;
      busy     <= 1'b0;
      rd_q     <= 1'b0;
      phase    <= '0;
      idx      <= '0;
      sh       <= '0;
      hold     <= '0;
      row      <= '0;
      rep      <= 1'b0;
      row_addr <= base_i;
    end else begin
      rd_q  <= rd_en_o;
      prime <= start;
      if (vcnt == VW'(VSB) && hcnt == '0) valid <= 1'b1;
      if (rd_q && busy) hold <= rd_data_i;
      if (prime) begin
        sh    <= rd_data_i;
        busy  <= 1'b1;
        phase <= '0;
        idx   <= IW'(1);
      end else if (busy) begin
        phase <= phase + 1'b1;
        if (phase == 4'hF) begin
          if (idx == IW'(BYTES)) busy <= 1'b0;
          else begin
            sh  <= hold;
            idx <= idx + 1'b1;
          end
        end else if (phase[0]) begin
          sh <= {sh[6:0], 1'b0};
        end
      end
      if (line_done) begin
        rep <= ~rep;
        if (rep) begin
          if (row == RW'(ROWS - 1)) begin
            row      <= '0;
            row_addr <= base_i;
            valid    <= 1'b0;
          end else begin
            row      <= row + 1'b1;
            row_addr <= row_addr + ADDR_W'(BYTES);
          end
        end
      end
    end
  end
endmodule

module fb_scanout_chk #(
  parameter int HTOT   = 1024,
  parameter int H_SYNC = 72,
  parameter int START  = 200,
  parameter int BYTES  = 52,
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int RW     = 9,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HW-1:0]     hcnt,
  input logic [VW-1:0]     vcnt,
  input logic              hsync_n_o,
  input logic              vsync_o,
  input logic              rd_en_o,
  input logic              valid,
  input logic              busy,
  input logic [RW-1:0]     row,
  input logic              rep,
  input logic [ADDR_W-1:0] row_addr,
  input logic [ADDR_W-1:0] base_i
);
  p_hsync_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n_o) |-> $past(hcnt) == HW'(H_SYNC - 1));
  p_vsync_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_o) |-> hcnt == '0 && vcnt == '0);
  p_start_dot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hcnt) == HW'(START + 1));
  p_read_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> valid);
  p_row_stride_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row) && row != '0) |-> row_addr == $past(row_addr) + ADDR_W'(BYTES));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> row == '0 && !rep && row_addr == $past(base_i));
endmodule

bind fb_scanout fb_scanout_chk #(
  .HTOT(HTOT), .H_SYNC(H_SYNC), .START(START), .BYTES(BYTES),
  .HW(HW), .VW(VW), .RW(RW), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
  .hsync_n_o(hsync_n_o), .vsync_o(vsync_o), .rd_en_o(rd_en_o),
  .valid(valid), .busy(busy), .row(row), .rep(rep),
  .row_addr(row_addr), .base_i(base_i)
);

// File: tb/fb_scanout_tb_top.sv
module fb_scanout_tb_top;
  localparam int HV = 64, HF = 8, HS = 8, HB = 20;
  localparam int VV = 8, VF = 1, VS = 2, VB = 3;
  localparam int AW = 12;
  localparam int HTOT = HV + HF + HS + HB;
  localparam int VTOT = VV + VF + VS + VB;
  localparam int START = HS + HB;
  localparam int VSB = VS + VB;
  localparam int BYTES = HV / 16 + 2;
  localparam int ROWS = VV / 2;
  localparam int RUN = 3 * HTOT * VTOT + 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] base = '0;
  logic rd_en, hsync_n, vsync, pix;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = '0;
  int n = 0, tests = 0, fails = 0;

  always #5 clk = ~clk;

  fb_scanout #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
               .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_i(base), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .hsync_n_o(hsync_n), .vsync_o(vsync), .pix_o(pix));

  function automatic logic [7:0] memf(int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic int base_of(int f);
    return (f == 1) ? BYTES * ROWS : 0;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memf(int'(rd_addr));
  always @(posedge clk) n <= rst_n ? n + 1 : 0;

  task automatic chk(bit ok, string r, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", r, n, act, exp);
    end
  endtask

  task automatic check_cycle();
    logic ep, er;
    int ea;
    logic [7:0] d;
    ep = 1'b0; er = 1'b0; ea = 0;
    for (int back = 0; back < 2; back++) begin
      int la, vb, f, s, rowb, k, j;
      la = n / HTOT - back;
      if (la < 0) continue;
      vb = la % VTOT;
      f = la / VTOT;
      if (vb < VSB || vb >= VSB + 2 * ROWS) continue;
      s = n - la * HTOT - START;
      rowb = base_of(f) + ((vb - VSB) / 2) * BYTES;
      if (s == 0) begin er = 1'b1; ea = rowb; end
      if (s >= 2 && s <= 1 + 16 * BYTES) begin
        k = (s - 2) / 16;
        j = ((s - 2) % 16) / 2;
        d = memf(rowb + k);
        ep = d[7 - j];
        if ((s - 2) % 16 == 0 && k < BYTES - 1) begin er = 1'b1; ea = rowb + k + 1; end
      end
    end
    chk(hsync_n == ((n % HTOT) >= HS), "R1 hsync", hsync_n, (n % HTOT) >= HS);
    chk(vsync == (((n / HTOT) % VTOT) < VS), "R2 vsync", vsync, ((n / HTOT) % VTOT) < VS);
    chk(rd_en == er, "R3 R6 R8 read strobe", rd_en, er);
    if (er) chk(int'(rd_addr) == ea, "R6 R7 R9 read address", int'(rd_addr), ea);
    chk(pix == ep, "R4 R5 R7 R9 pixel", pix, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pix == 1'b0, "R10 reset pix", pix, 0);
    chk(rd_en == 1'b0, "R10 reset rd_en", rd_en, 0);
    chk(hsync_n == 1'b0, "R10 reset hsync", hsync_n, 0);
    chk(vsync == 1'b1, "R10 reset vsync", vsync, 1);
    rst_n = 1'b1;
    while (n < RUN) begin
      @(negedge clk);
      check_cycle();
      if (n == 500) base = AW'(BYTES * ROWS);
      if (n == HTOT * VTOT + 500) base = '0;
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (RUN + 2000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", n, RUN);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule